// File: doc/BRIEF.md
# Eight-bit ALU with full flag byte

This block is the arithmetic and logic unit of an 8-bit datapath. It works on an accumulator byte and an operand byte and returns a new accumulator value, a write strobe for it and a new eight-bit flag byte. The flag byte follows a fixed, exact rule for every operation. That includes the two spare flag bits that copy result bits 5 and 3. Compare takes those two bits from the operand. Increment and decrement keep the carry. Decimal adjust corrects the accumulator from the incoming half-carry, subtract and carry flags.

All arithmetic is combinational. One register stage holds the result byte, write strobe and flag byte, so each output appears on the clock edge after its inputs were applied. The carry used by add-with-carry and subtract-with-carry comes from a separate `cin_i` input. Every other operation that reads or keeps an old flag takes it from the `flags_i` byte. Register files, memory, 16-bit arithmetic and instruction decoding belong to other blocks.

Top module: `byte_alu_flags`

## Requirements
- R1: Outputs are registered. The result, write strobe and flags for inputs applied before a rising edge appear after that edge. While `rst_n` is low, all outputs are zero.
- R2: The flag byte layout, from bit 7 down, is: sign, zero, copy of result bit 5, half-carry, copy of result bit 3, parity/overflow, subtract, carry. Unless a requirement below says otherwise, sign is result bit 7, zero is set when the result is 0x00, and the two copy bits take result bits 5 and 3.
- R3: Add (op 0) gives A+B. Add with carry (op 1) gives A+B+cin. Half-carry is the carry out of bit 3, carry is the carry out of bit 7, parity/overflow is signed overflow, and subtract is 0.
- R4: Subtract (op 2) gives A−B. Subtract with carry (op 3) gives A−B−cin. Half-carry is the borrow out of bit 3, carry is the borrow out of bit 7, parity/overflow is signed overflow, and subtract is 1.
- R5: Compare (op 4) sets the flags as subtract does, except that flag bits 5 and 3 copy operand bits 5 and 3. The write strobe is low and the result byte equals A.
- R6: AND (op 5) gives A&B with half-carry 1, subtract 0, carry 0, and parity/overflow set when the result has an even number of one bits.
- R7: OR (op 6) and XOR (op 7) give A|B and A^B with half-carry 0, subtract 0, carry 0, and even parity in parity/overflow.
- R8: Increment (op 8) and decrement (op 9) give A+1 and A−1. Overflow is set for 0x7F→0x80 and for 0x80→0x7F. Half-carry is the carry or borrow at bit 3. Subtract is 0 for increment and 1 for decrement. Carry is copied from `flags_i[0]`.
- R9: Complement (op 10) gives ~A. Half-carry and subtract are set to 1. Bits 5 and 3 copy the new A. Sign, zero, parity/overflow and carry are copied from `flags_i`.
- R10: Decimal adjust (op 11) forms a correction: 0x06 when `flags_i[4]` is set or A[3:0] > 9, plus 0x60 when `flags_i[0]` is set or A > 0x99. The correction is subtracted from A when `flags_i[1]` is set and added otherwise.
- R11: After decimal adjust, carry is `flags_i[0]` OR (A > 0x99). Half-carry is A[4] XOR result[4]. Parity/overflow is the even parity of the result. Subtract is copied from `flags_i[1]`.
- R12: The write strobe is high for ops 0–3 and 5–11. Op codes 12–15 return the result A, a low strobe and `flags_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| cin_i | input | 1 | Carry in for add/subtract with carry |
| flags_i | input | 8 | Incoming flag byte |
| res_o | output | 8 | Registered result byte |
| res_we_o | output | 1 | Registered result write strobe |
| flags_o | output | 8 | Registered new flag byte |

## Verification
Every cycle, the assertions check the flag rules that depend only on the operation and a few input bits:
- the forced half-carry, subtract and carry values of the logic operations;
- carry kept by increment and decrement;
- the copied flags and inverted result of complement;
- compare taking its spare bits from the operand with a low write strobe;
- the subtract flag of the add and subtract families.

Results that need real arithmetic can only be shown by the bench scenarios, which compare against an independently written integer model. These are the carry, borrow and overflow values of add and subtract, the decimal-adjust corrections over every accumulator value and flag mix, and the parity values.

// File: rtl/byte_alu_flags.sv
module byte_alu_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       cin_i,
  input  logic [7:0] flags_i,
  output logic [7:0] res_o,
  output logic       res_we_o,
  output logic [7:0] flags_o
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
                         OP_INC = 4'd8, OP_DEC = 4'd9, OP_CPL = 4'd10, OP_DAA = 4'd11;

  logic       is_step, is_sub;
  logic [7:0] b_arg;
  logic       c_arg;
  logic [8:0] full;
  logic [4:0] half;
  logic       ovf;

  assign is_step = (op_i == OP_INC) || (op_i == OP_DEC);
  assign is_sub  = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP) || (op_i == OP_DEC);
  assign b_arg   = is_step ? 8'h01 : opnd_i;
  assign c_arg   = ((op_i == OP_ADC) || (op_i == OP_SBC)) ? cin_i : 1'b0;

  assign full = is_sub ? ({1'b0, acc_i} - {1'b0, b_arg} - {8'b0, c_arg})
                       : ({1'b0, acc_i} + {1'b0, b_arg} + {8'b0, c_arg});
  assign half = is_sub ? ({1'b0, acc_i[3:0]} - {1'b0, b_arg[3:0]} - {4'b0, c_arg})
                       : ({1'b0, acc_i[3:0]} + {1'b0, b_arg[3:0]} + {4'b0, c_arg});
  assign ovf  = is_sub ? ((acc_i[7] ^ b_arg[7]) & (full[7] ^ acc_i[7]))
                       : (~(acc_i[7] ^ b_arg[7]) & (full[7] ^ acc_i[7]));

  logic       lo_fix, hi_fix;
  logic [7:0] adj, daa_val;

  assign lo_fix  = flags_i[4] | (acc_i[3:0] > 4'd9);
  assign hi_fix  = flags_i[0] | (acc_i > 8'h99);
  assign adj     = {1'b0, hi_fix, hi_fix, 2'b00, lo_fix, lo_fix, 1'b0};
  assign daa_val = flags_i[1] ? (acc_i - adj) : (acc_i + adj);

  logic [7:0] r_n, f_n;
  logic       we_n;

  always_comb begin
    r_n  = acc_i;
    we_n = 1'b1;
    f_n  = flags_i;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        r_n = full[7:0];
        f_n = {full[7], full[7:0] == 8'h00, full[5], half[4], full[3], ovf, is_sub, full[8]};
      end
      OP_CMP: begin
        we_n = 1'b0;
        f_n  = {full[7], full[7:0] == 8'h00, opnd_i[5], half[4], opnd_i[3], ovf, 1'b1, full[8]};
      end
      OP_AND, OP_OR, OP_XOR: begin
        r_n = (op_i == OP_AND) ? (acc_i & opnd_i) :
              (op_i == OP_OR)  ? (acc_i | opnd_i) : (acc_i ^ opnd_i);
        f_n = {r_n[7], r_n == 8'h00, r_n[5], op_i == OP_AND, r_n[3], ~^r_n, 1'b0, 1'b0};
      end
      OP_INC, OP_DEC: begin
        r_n = full[7:0];
        f_n = {full[7], full[7:0] == 8'h00, full[5], half[4], full[3], ovf, is_sub, flags_i[0]};
      end
      OP_CPL: begin
        r_n = ~acc_i;
        f_n = {flags_i[7:6], r_n[5], 1'b1, r_n[3], flags_i[2], 1'b1, flags_i[0]};
      end
      OP_DAA: begin
        r_n = daa_val;
        f_n = {r_n[7], r_n == 8'h00, r_n[5], acc_i[4] ^ r_n[4], r_n[3], ~^r_n,
               flags_i[1], flags_i[0] | (acc_i > 8'h99)};
      end
      default: we_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o    <= 8'h00;
      res_we_o <= 1'b0;
      flags_o  <= 8'h00;
    end else begin
      res_o    <= r_n;
      res_we_o <= we_n;
      flags_o  <= f_n;
    end
  end
endmodule

// File: rtl/byte_alu_flags_chk.sv
module byte_alu_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic       cin_i,
  input logic [7:0] flags_i,
  input logic [7:0] res_o,
  input logic       res_we_o,
  input logic [7:0] flags_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (res_o == 8'h00 && !res_we_o && flags_o == 8'h00));

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd4 |=> (!res_we_o && res_o == $past(acc_i) && flags_o[1]));

  // R5
  cmp_spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd4 |=> (flags_o[5] == $past(opnd_i[5]) && flags_o[3] == $past(opnd_i[3])));

  // R6
  and_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd5 |=> (flags_o[4] && !flags_o[1] && !flags_o[0]));

  // R7
  or_xor_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd6 || op_i == 4'd7) |=> (!flags_o[4] && !flags_o[1] && !flags_o[0]));

  // R8
  step_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd8 || op_i == 4'd9) |=> (flags_o[0] == $past(flags_i[0]) && flags_o[1] == $past(op_i[0])));

  // R9
  cpl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd10 |=> (res_o == ~$past(acc_i) && flags_o[7:6] == $past(flags_i[7:6]) &&
                       flags_o[2] == $past(flags_i[2]) && flags_o[0] == $past(flags_i[0]) &&
                       flags_o[4] && flags_o[1]));

  // R3
  add_n_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0 || op_i == 4'd1) |=> (!flags_o[1] && res_we_o));

  // R4
  sub_n_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd2 || op_i == 4'd3) |=> (flags_o[1] && res_we_o));

  // R12
  undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i >= 4'd12 |=> (!res_we_o && res_o == $past(acc_i) && flags_o == $past(flags_i)));

  // R2
  sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i <= 4'd3 || (op_i >= 4'd5 && op_i <= 4'd9) || op_i == 4'd11) |=>
      (flags_o[7] == res_o[7] && flags_o[6] == (res_o == 8'h00) &&
       flags_o[5] == res_o[5] && flags_o[3] == res_o[3]));
endmodule

bind byte_alu_flags byte_alu_flags_chk u_chk (.*);

// File: tb/byte_alu_flags_tb.sv
module byte_alu_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = 8'h00, opnd_i = 8'h00, flags_i = 8'h00;
  logic       cin_i = 1'b0;
  logic [7:0] res_o, flags_o;
  logic       res_we_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  byte_alu_flags u_dut (.*);

  function automatic int par_even(input int v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += (v >> i) & 1;
    return (c % 2 == 0) ? 1 : 0;
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {we, result, flags}
  function automatic logic [16:0] model(input int op, input int a, input int b, input int c, input int f);
    int r, t, st, s, z, y, h, x, p, n, cy, we, cc;
    bit own_sz = 1, own_yx = 1;
    we = 1; r = a; s = 0; z = 0; y = 0; x = 0; h = 0; p = 0; n = 0; cy = 0;
    case (op)
      0, 1: begin
        cc = (op == 1) ? c : 0;
        t = a + b + cc; r = t & 255; cy = (t > 255);
        h = (((a & 15) + (b & 15) + cc) > 15);
        st = sgn(a) + sgn(b) + cc; p = (st > 127 || st < -128);
      end
      2, 3, 4: begin
        cc = (op == 3) ? c : 0;
        t = a - b - cc; r = t & 255; cy = (t < 0); n = 1;
        h = (((a & 15) - (b & 15) - cc) < 0);
        st = sgn(a) - sgn(b) - cc; p = (st > 127 || st < -128);
        if (op == 4) begin
          s = (r >> 7) & 1; z = (r == 0); y = (b >> 5) & 1; x = (b >> 3) & 1;
          own_sz = 0; own_yx = 0; r = a; we = 0;
        end
      end
      5: begin r = a & b; h = 1; p = par_even(r); end
      6: begin r = a | b; p = par_even(r); end
      7: begin r = a ^ b; p = par_even(r); end
      8: begin r = (a + 1) & 255; h = ((a & 15) == 15); p = (a == 127); cy = f & 1; end
      9: begin r = (a + 255) & 255; h = ((a & 15) == 0); p = (a == 128); n = 1; cy = f & 1; end
      10: begin
        r = (~a) & 255; s = (f >> 7) & 1; z = (f >> 6) & 1; p = (f >> 2) & 1; cy = f & 1;
        h = 1; n = 1; own_sz = 0;
      end
      11: begin
        t = 0;
        if (((f >> 4) & 1) == 1 || (a & 15) > 9) t += 6;
        if ((f & 1) == 1 || a > 153) t += 96;
        r = (((f >> 1) & 1) == 1) ? ((a - t) & 255) : ((a + t) & 255);
        cy = (f & 1) | (a > 153 ? 1 : 0);
        h = ((a >> 4) & 1) ^ ((r >> 4) & 1);
        p = par_even(r); n = (f >> 1) & 1;
      end
      default: return {1'b0, a[7:0], f[7:0]};
    endcase
    if (own_sz) begin s = (r >> 7) & 1; z = (r == 0); end
    if (own_yx) begin y = (r >> 5) & 1; x = (r >> 3) & 1; end
    t = (s << 7) | (z << 6) | (y << 5) | (h << 4) | (x << 3) | (p << 2) | (n << 1) | cy;
    return {we[0], r[7:0], t[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got we=%0d res=%02h flags=%02h, expected we=%0d res=%02h flags=%02h",
               tag, got[16], got[15:8], got[7:0], exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic run(input int op, input int a, input int b, input int c, input int f, input string tag);
    @(negedge clk);
    op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; cin_i = c[0]; flags_i = f[7:0];
    @(posedge clk);
    @(negedge clk);
    chk(tag, {res_we_o, res_o, flags_o}, model(op, a, b, c, f));
  endtask

  task automatic run_fixed(input int op, input int a, input int b, input int c, input int f,
                           input logic [16:0] exp, input string tag);
    @(negedge clk);
    op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; cin_i = c[0]; flags_i = f[7:0];
    @(posedge clk);
    @(negedge clk);
    chk(tag, {res_we_o, res_o, flags_o}, exp);
  endtask

  task automatic t_reset;
    op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'hFF; flags_i = 8'hFF; cin_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset", {res_we_o, res_o, flags_o}, 17'h0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 first edge", {res_we_o, res_o, flags_o}, model(0, 255, 255, 1, 255));
  endtask

  task automatic t_add;
    run_fixed(0, 8'h7F, 8'h01, 0, 0, {1'b1, 8'h80, 8'h94}, "R3 R2 add 7F+01");
    run_fixed(0, 8'hFF, 8'h01, 0, 0, {1'b1, 8'h00, 8'h51}, "R3 R2 add FF+01");
    for (int a = 0; a < 256; a += 15)
      for (int b = 0; b < 256; b += 13) begin
        run(0, a, b, 1, 0, "R3 add");
        run(1, a, b, a & 1, 0, "R3 adc");
      end
  endtask

  task automatic t_sub;
    for (int a = 0; a < 256; a += 17)
      for (int b = 0; b < 256; b += 11) begin
        run(2, a, b, 1, 0, "R4 sub");
        run(3, a, b, b & 1, 0, "R4 sbc");
      end
    run(3, 8'h80, 8'h00, 1, 0, "R4 sbc overflow");
  endtask

  task automatic t_cmp;
    run_fixed(4, 8'h10, 8'h28, 0, 0, {1'b0, 8'h10, 8'hBB}, "R5 cmp 10-28");
    for (int a = 0; a < 256; a += 19)
      for (int b = 0; b < 256; b += 7) run(4, a, b, 1, 8'hFF, "R5 cmp");
  endtask

  task automatic t_logic;
    for (int a = 0; a < 256; a += 23)
      for (int b = 0; b < 256; b += 29) begin
        run(5, a, b, 1, 8'hFF, "R6 and");
        run(6, a, b, 1, 8'hFF, "R7 or");
        run(7, a, b, 1, 8'hFF, "R7 xor");
      end
  endtask

  task automatic t_step;
    for (int a = 0; a < 256; a++) begin
      run(8, a, 8'h55, 0, a & 1, "R8 inc");
      run(9, a, 8'h55, 0, (a >> 1) & 1, "R8 dec");
    end
  endtask

  task automatic t_cpl;
    for (int a = 0; a < 256; a += 37) begin
      run(10, a, 0, 0, 8'hC5, "R9 cpl");
      run(10, a, 0, 0, 8'h3A, "R9 cpl");
    end
  endtask

  task automatic t_daa;
    run_fixed(11, 8'h9A, 0, 0, 0, {1'b1, 8'h00, 8'h55}, "R10 R11 daa 9A");
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 256; a++)
        run(11, a, 0, 0, ((f & 4) << 2) | (f & 3), "R10 R11 daa");
  endtask

  task automatic t_undef;
    for (int op = 12; op < 16; op++) run(op, 8'hA5, 8'h3C, 1, 8'h69, "R12 undefined op");
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_step();
    t_cpl();
    t_daa();
    t_undef();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule